// File: doc/BRIEF.md
# Serial Memory Slave with Guarded Control Register

This block is the two-wire bus slave front end of a small byte-addressed memory. It watches an already-synchronised clock line and data line and finds start and stop conditions, and it decodes a device-select byte and a word address. It then serves single-byte writes, page writes, reads from the internal address counter, and random reads. The data line is driven through one open-drain pull-low request. The memory is an inferred register array. Written bytes are collected in a page staging buffer and copied into the array only when the master ends the transfer with a stop. That copy starts a modelled internal write cycle. While the cycle runs, the slave leaves the bus alone, so a master finds out that the write has finished by repeating device-select bytes until one is acknowledged.

A separate control register sits at the ninth-bit address 1FFh. It holds a two-bit watchdog select, which leaves the block on its own port, and three block-protect bits that lock regions of the array against writes. Access to it follows a one-byte protocol with its own rules. A reserved data value arms a write-enable latch. Only the next store is accepted, and that store clears the latch. A read of the register returns one byte, after which the slave drops off the bus without waiting for the master.

Top module: `sm_slave`

## Requirements
- R1: The device-select byte is acknowledged only when bits 7..4 equal 1010b and bits 3..2 equal 00b. Bit 1 is word-address bit 8 and bit 0 is read (1) or write (0). Any other value is not acknowledged. The slave changes its pull request only while SCL is low.
- R2: In a write, the word-address byte and every array data byte are acknowledged. Bytes go to consecutive offsets inside a 16-byte page, and the offset wraps within the page. The array changes only at the stop; a start before the stop discards the staged bytes.
- R3: A stop after accepted, unprotected array data starts an internal write cycle of WRITE_CYCLES clocks. During that cycle device-select bytes are not acknowledged. Afterwards they are.
- R4: A random read (address, repeated start, read) returns the addressed byte. While the master acknowledges, the following bytes come from incrementing addresses that wrap from FFh to 00h. A read with no address phase continues from the counter, which points one past the last byte read.
- R5: Protection by code bp: 0 protects nothing, 1 protects addresses C0h-FFh, 2 protects 80h-FFh, and 3 to 7 protect the whole array.
- R6: A write to a protected page is still acknowledged, but leaves the array unchanged and starts no write cycle.
- R7: Word address FFh with address bit 8 set selects the control register. Any other address with bit 8 set is not acknowledged. A read of the register returns {wd[1:0], bp[2:0], 0, wel, 0} (bit 7 down to 0). After that byte the slave releases the line and is idle, so a further byte reads FFh.
- R8: A control-register write acknowledges only its first data byte. Later bytes are not acknowledged.
- R9: Data 02h sets the write-enable latch at the stop, with no write cycle. Any other value, when the latch is set, loads wd from bits 7..6 and bp from bits 5..3, clears the latch and starts a write cycle. When the latch is clear, the value is acknowledged but ignored and no write cycle starts.
- R10: After reset, the array reads all zero, the counter is 0, the control register is 00h, the line is released and the watchdog select is 0.
- R11: The watchdog select output equals the stored wd field and changes only together with the start of a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired value) |
| sda_pull_o | output | 1 | 1 requests the data line be pulled low |
| wdsel_o | output | 2 | Stored watchdog select field |

## Verification
The assertions take for granted that the master holds SCL low for at least two system clocks after each falling edge. They also assume the master never makes a start or stop while the slave is pulling the data line, since the pull-change rule is stated relative to SCL. The bench's bit tasks keep each SCL phase four clocks long, move data only while SCL is low, and release the line during acknowledge and read bits. Stops are issued only after a bit in which the slave has already let go.

// File: rtl/sm_pkg.sv
package sm_pkg;
    typedef enum logic [2:0] {
        BUS_IDLE, BUS_RX, BUS_ACK, BUS_TX, BUS_RACK, BUS_SKIP
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_DEV, PH_WADDR, PH_DATA
    } phase_e;

    localparam logic [3:0] DEV_ID     = 4'b1010;
    localparam logic [7:0] ARM_CODE   = 8'h02;
    localparam logic [7:0] CREG_LOW   = 8'hFF;
endpackage

// File: rtl/sm_linemon.sv
module sm_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise = !scl_q && scl_i;
    assign scl_fall = scl_q && !scl_i;
    assign start_ev = scl_q && scl_i && sda_q && !sda_i;
    assign stop_ev  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/sm_guard.sv
module sm_guard (
    input  logic [2:0] bp,
    input  logic [1:0] quarter,
    output logic       locked
);
    always_comb begin
        case (bp)
            3'd0:    locked = 1'b0;
            3'd1:    locked = &quarter;
            3'd2:    locked = quarter[1];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/sm_store.sv
module sm_store #(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stg_we,
    input  logic [PW-1:0]    stg_idx,
    input  logic [7:0]       stg_data,
    input  logic             stg_clr,
    input  logic             commit,
    input  logic [AW-PW-1:0] page,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int PB    = 1 << PW;

    logic [7:0]    mem_q [DEPTH];
    logic [7:0]    stg_q [PB];
    logic [PB-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            for (int j = 0; j < PB; j++) stg_q[j] <= '0;
            vld_q <= '0;
        end else if (commit) begin
            for (int k = 0; k < PB; k++) begin
                if (vld_q[k]) mem_q[{page, PW'(k)}] <= stg_q[k];
            end
            vld_q <= '0;
        end else if (stg_clr) begin
            vld_q <= '0;
        end else if (stg_we) begin
            stg_q[stg_idx] <= stg_data;
            vld_q[stg_idx] <= 1'b1;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sm_slave.sv
module sm_slave #(
    parameter int AW           = 8,
    parameter int PW           = 4,
    parameter int WRITE_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [1:0] wdsel_o
);
    import sm_pkg::*;

    localparam int CW = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        bus_st_e       st;
        phase_e        ph;
        logic [3:0]    bitcnt;
        logic [7:0]    sh;
        logic          rw;
        logic          hi;
        logic          cr_sel;
        logic          rd_cr;
        logic          first;
        logic [AW-1:0] ptr;
        logic          pend_arr;
        logic          pend_cr;
        logic [7:0]    cr_data;
        logic          wel;
        logic [1:0]    wd;
        logic [2:0]    bp;
        logic [CW-1:0] wc;
        logic          pull;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic          scl_rise, scl_fall, start_ev, stop_ev;
    logic          busy, prot_hit, commit, stg_we, stg_clr;
    logic [7:0]    rd_data, cr_byte;
    logic [1:0]    ptr_quarter;
    logic [2:0]    cur_bp;

    sm_linemon i_linemon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    assign ptr_quarter = ctl_q.ptr[AW-1 -: 2];
    assign cur_bp      = ctl_q.bp;

    sm_guard i_guard (
        .bp      (cur_bp),
        .quarter (ptr_quarter),
        .locked  (prot_hit)
    );

    sm_store #(.AW(AW), .PW(PW)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .stg_we   (stg_we),
        .stg_idx  (ctl_q.ptr[PW-1:0]),
        .stg_data (ctl_q.sh),
        .stg_clr  (stg_clr),
        .commit   (commit),
        .page     (ctl_q.ptr[AW-1:PW]),
        .rd_addr  (ctl_q.ptr),
        .rd_data  (rd_data)
    );

    assign busy    = (ctl_q.wc != '0);
    assign cr_byte = {ctl_q.wd, ctl_q.bp, 1'b0, ctl_q.wel, 1'b0};

    always_comb begin
        ctl_d   = ctl_q;
        stg_we  = 1'b0;
        stg_clr = 1'b0;
        commit  = 1'b0;
        if (busy) ctl_d.wc = ctl_q.wc - 1'b1;

        if (stop_ev) begin
            if (ctl_q.pend_arr) begin
                if (prot_hit) begin
                    stg_clr = 1'b1;
                end else begin
                    commit   = 1'b1;
                    ctl_d.wc = CW'(WRITE_CYCLES);
                end
            end
            if (ctl_q.pend_cr) begin
                if (ctl_q.cr_data == ARM_CODE) begin
                    ctl_d.wel = 1'b1;
                end else if (ctl_q.wel) begin
                    ctl_d.wd  = ctl_q.cr_data[7:6];
                    ctl_d.bp  = ctl_q.cr_data[5:3];
                    ctl_d.wel = 1'b0;
                    ctl_d.wc  = CW'(WRITE_CYCLES);
                end
            end
            ctl_d.pend_arr = 1'b0;
            ctl_d.pend_cr  = 1'b0;
            ctl_d.cr_sel   = 1'b0;
            ctl_d.rd_cr    = 1'b0;
            ctl_d.st       = BUS_IDLE;
        end else if (start_ev) begin
            stg_clr        = ctl_q.pend_arr;
            ctl_d.pend_arr = 1'b0;
            ctl_d.pend_cr  = 1'b0;
            ctl_d.rd_cr    = 1'b0;
            ctl_d.bitcnt   = '0;
            ctl_d.ph       = PH_DEV;
            ctl_d.st       = busy ? BUS_IDLE : BUS_RX;
        end else begin
            case (ctl_q.st)
                BUS_RX: begin
                    if (scl_rise) begin
                        ctl_d.sh     = {ctl_q.sh[6:0], sda_i};
                        ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
                    end else if (scl_fall && ctl_q.bitcnt == 4'd8) begin
                        ctl_d.bitcnt = '0;
                        ctl_d.st     = BUS_ACK;
                        case (ctl_q.ph)
                            PH_DEV: begin
                                if (ctl_q.sh[7:4] == DEV_ID && ctl_q.sh[3:2] == 2'b00) begin
                                    ctl_d.rw = ctl_q.sh[0];
                                    ctl_d.hi = ctl_q.sh[1];
                                    if (!ctl_q.sh[0]) ctl_d.ph = PH_WADDR;
                                end else begin
                                    ctl_d.st = BUS_SKIP;
                                end
                            end
                            PH_WADDR: begin
                                if (!ctl_q.hi) begin
                                    ctl_d.ptr    = ctl_q.sh[AW-1:0];
                                    ctl_d.cr_sel = 1'b0;
                                    ctl_d.first  = 1'b1;
                                    ctl_d.ph     = PH_DATA;
                                end else if (ctl_q.sh == CREG_LOW) begin
                                    ctl_d.cr_sel = 1'b1;
                                    ctl_d.first  = 1'b1;
                                    ctl_d.ph     = PH_DATA;
                                end else begin
                                    ctl_d.st = BUS_SKIP;
                                end
                            end
                            default: begin
                                if (ctl_q.cr_sel) begin
                                    if (ctl_q.first) begin
                                        ctl_d.cr_data = ctl_q.sh;
                                        ctl_d.pend_cr = 1'b1;
                                        ctl_d.first   = 1'b0;
                                    end else begin
                                        ctl_d.st = BUS_SKIP;
                                    end
                                end else begin
                                    stg_we = 1'b1;
                                    ctl_d.ptr[PW-1:0] = ctl_q.ptr[PW-1:0] + 1'b1;
                                    ctl_d.pend_arr    = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                BUS_ACK: begin
                    if (scl_fall) begin
                        ctl_d.bitcnt = '0;
                        if (ctl_q.rw) begin
                            ctl_d.st = BUS_TX;
                            if (ctl_q.cr_sel) begin
                                ctl_d.sh    = cr_byte;
                                ctl_d.rd_cr = 1'b1;
                            end else begin
                                ctl_d.sh  = rd_data;
                                ctl_d.ptr = ctl_q.ptr + 1'b1;
                            end
                        end else begin
                            ctl_d.st = BUS_RX;
                        end
                    end
                end
                BUS_TX: begin
                    if (scl_fall) begin
                        ctl_d.sh     = {ctl_q.sh[6:0], 1'b0};
                        ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
                        if (ctl_q.bitcnt == 4'd7) begin
                            ctl_d.bitcnt = '0;
                            if (ctl_q.rd_cr) begin
                                ctl_d.st     = BUS_IDLE;
                                ctl_d.rd_cr  = 1'b0;
                                ctl_d.cr_sel = 1'b0;
                            end else begin
                                ctl_d.st = BUS_RACK;
                            end
                        end
                    end
                end
                BUS_RACK: begin
                    if (scl_rise) begin
                        if (sda_i) ctl_d.st = BUS_SKIP;
                        else ctl_d.bitcnt = 4'd1;
                    end else if (scl_fall && ctl_q.bitcnt == 4'd1) begin
                        ctl_d.st     = BUS_TX;
                        ctl_d.bitcnt = '0;
                        ctl_d.sh     = rd_data;
                        ctl_d.ptr    = ctl_q.ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        ctl_d.pull = (ctl_d.st == BUS_ACK) || (ctl_d.st == BUS_TX && !ctl_d.sh[7]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sda_pull_o = ctl_q.pull;
    assign wdsel_o    = ctl_q.wd;
endmodule

// File: rtl/sm_checker.sv
module sm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_pull_o,
    input logic [1:0] wdsel_o,
    input logic       wc_busy,
    input logic       commit,
    input logic [1:0] ptr_quarter,
    input logic [2:0] bp_cur
);
    logic locked;

    always_comb begin
        if (bp_cur == 3'd0)      locked = 1'b0;
        else if (bp_cur == 3'd1) locked = (ptr_quarter == 2'd3);
        else if (bp_cur == 3'd2) locked = (ptr_quarter >= 2'd2);
        else                     locked = 1'b1;
    end

    AST_PULL_WHEN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_i); // R1
    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wc_busy |-> !sda_pull_o); // R3
    AST_CYCLE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wc_busy) |=> wc_busy); // R3
    AST_LOCKED_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !locked); // R6
    AST_WDSEL_WITH_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wdsel_o != $past(wdsel_o)) |-> wc_busy); // R11
endmodule

bind sm_slave sm_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_pull_o  (sda_pull_o),
    .wdsel_o     (wdsel_o),
    .wc_busy     (busy),
    .commit      (commit),
    .ptr_quarter (ptr_quarter),
    .bp_cur      (cur_bp)
);

// File: tb/test_sm_slave.sv
module test_sm_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull;
    logic [1:0] wdsel;
    wire        sda_bus = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    sm_slave i_sm_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .wdsel_o    (wdsel)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] mem_m [256];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic [2:0] bp_m = '0;
    logic [1:0] wd_m = '0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(2);
        scl = 1'b1;   tick(4);
        m_sda = 1'b0; tick(4);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(2);
        scl = 1'b1;   tick(4);
        m_sda = 1'b1; tick(4);
    endtask

    task automatic wbit(input logic b);
        m_sda = b; tick(2);
        scl = 1'b1; tick(4);
        scl = 1'b0; tick(2);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; tick(2);
        scl = 1'b1; tick(2);
        b = sda_bus; tick(2);
        scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit mack);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            rbit(b);
            d = {d[6:0], b};
        end
        wbit(!mack);
    endtask

    function automatic logic [7:0] dev(input logic hi, input logic rw);
        return {4'b1010, 2'b00, hi, rw};
    endfunction

    function automatic bit prot_m(input logic [2:0] bp, input int a);
        if (bp == 0) return 1'b0;
        if (bp == 1) return a >= 192;
        if (bp == 2) return a >= 128;
        return 1'b1;
    endfunction

    // acks: bit0 device byte, bit1 address byte, bit 2+k data byte k
    task automatic write_txn(input logic [8:0] a, input int n, output logic [17:0] acks);
        bit k;
        acks = '0;
        bus_start;
        send_byte(dev(a[8], 1'b0), k); acks[0] = k;
        send_byte(a[7:0], k);          acks[1] = k;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k);
            acks[2+i] = k;
        end
        bus_stop;
    endtask

    task automatic poll(output int tries);
        bit k;
        tries = 0;
        do begin
            tries++;
            bus_start;
            send_byte(dev(1'b0, 1'b0), k);
            bus_stop;
        end while (!k && tries < 40);
    endtask

    task automatic read_seq(input logic [8:0] a, input int n);
        bit k;
        bus_start;
        send_byte(dev(a[8], 1'b0), k);
        send_byte(a[7:0], k);
        bus_start;
        send_byte(dev(1'b0, 1'b1), k);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
        bus_stop;
    endtask

    task automatic cur_read(output logic [7:0] d);
        bit k;
        bus_start;
        send_byte(dev(1'b0, 1'b1), k);
        recv_byte(d, 1'b0);
        bus_stop;
    endtask

    function automatic logic [7:0] creg_m(input logic wel);
        return {wd_m, bp_m, 1'b0, wel, 1'b0};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [17:0] acks;
        logic [7:0]  d;
        int          t;
        bit          k;

        for (int i = 0; i < 256; i++) mem_m[i] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R10 reset state
        check("R10 pull released", int'(sda_pull), 0);
        check("R10 wdsel", int'(wdsel), 0);
        cur_read(d);
        check("R10 counter at 0 reads zero", d, 0);
        read_seq(9'h1FF, 1);
        check("R10 R7 control reg after reset", rbuf[0], 0);
        read_seq(9'h033, 1);
        check("R10 array zero", rbuf[0], 0);

        // R1 device-select sweep over upper six bits
        for (int v = 0; v < 64; v++) begin
            bus_start;
            send_byte({v[5:0], 2'b00}, k);
            bus_stop;
            check($sformatf("R1 select %02h", v << 2), int'(k), int'(v == 6'b101000));
        end

        // R2 R3 R4 single-byte writes
        for (int i = 0; i < 8; i++) begin
            int a;
            a = (i * 37) % 256;
            wbuf[0] = 8'((i * 29) + 3);
            write_txn(9'(a), 1, acks);
            check("R2 byte write acks", int'(acks[2:0]), 7);
            poll(t);
            check("R3 poll nacked during cycle", int'(t > 1), 1);
            mem_m[a] = wbuf[0];
            read_seq(9'(a), 1);
            check($sformatf("R2 R4 readback %02h", a), rbuf[0], mem_m[a]);
        end

        // R2 page write with wrap inside the page
        for (int k2 = 0; k2 < 7; k2++) wbuf[k2] = 8'(8'hA0 + k2);
        write_txn(9'h04C, 7, acks);
        check("R2 page acks", int'(acks[8:0]), 9'h1FF);
        poll(t);
        check("R3 page cycle", int'(t > 1), 1);
        for (int k2 = 0; k2 < 7; k2++) mem_m[8'h40 + ((12 + k2) % 16)] = wbuf[k2];
        read_seq(9'h040, 16);
        for (int k2 = 0; k2 < 16; k2++)
            check($sformatf("R2 R4 page byte %0d", k2), rbuf[k2], mem_m[8'h40 + k2]);

        // R4 sequential wrap and counter continuation
        read_seq(9'h0FE, 4);
        for (int k2 = 0; k2 < 4; k2++)
            check("R4 wrap read", rbuf[k2], mem_m[(254 + k2) % 256]);
        cur_read(d);
        check("R4 counter continues", d, mem_m[2]);

        // R2 start before stop discards
        bus_start;
        send_byte(dev(1'b0, 1'b0), k);
        send_byte(8'h20, k);
        send_byte(8'h55, k);
        bus_start;
        bus_stop;
        poll(t);
        check("R2 aborted write no cycle", t, 1);
        read_seq(9'h020, 1);
        check("R2 aborted write no change", rbuf[0], mem_m[8'h20]);

        // R7 bad high address
        wbuf[0] = 8'h11;
        write_txn(9'h100, 1, acks);
        check("R7 high address nacked", int'(acks[1:0]), 1);

        // R9 write without latch ignored
        wbuf[0] = 8'hD8;
        write_txn(9'h1FF, 1, acks);
        check("R9 unarmed acked", int'(acks[2:0]), 7);
        poll(t);
        check("R9 unarmed no cycle", t, 1);
        read_seq(9'h1FF, 1);
        check("R9 unarmed unchanged", rbuf[0], creg_m(1'b0));

        // R9 arm, R8 second byte nacked
        wbuf[0] = 8'h02;
        write_txn(9'h1FF, 1, acks);
        poll(t);
        check("R9 arm no cycle", t, 1);
        read_seq(9'h1FF, 1);
        check("R9 latch visible", rbuf[0], creg_m(1'b1));
        wbuf[0] = 8'h80;
        wbuf[1] = 8'hFF;
        write_txn(9'h1FF, 2, acks);
        check("R8 first acked second not", int'(acks[3:0]), 7);
        poll(t);
        check("R9 store starts cycle", int'(t > 1), 1);
        wd_m = 2'b10;
        read_seq(9'h1FF, 1);
        check("R9 stored and latch cleared", rbuf[0], creg_m(1'b0));
        check("R11 wdsel follows", int'(wdsel), int'(wd_m));

        // R5 R6 protection sweep over all codes and quarters
        for (int b = 0; b < 8; b++) begin
            wbuf[0] = 8'h02;
            write_txn(9'h1FF, 1, acks);
            poll(t);
            wbuf[0] = {2'(b), 3'(b), 3'b000};
            write_txn(9'h1FF, 1, acks);
            poll(t);
            check("R3 R9 control store cycle", int'(t > 1), 1);
            bp_m = 3'(b);
            wd_m = 2'(b);
            read_seq(9'h1FF, 1);
            check("R7 R9 control readback", rbuf[0], creg_m(1'b0));
            check("R11 wdsel", int'(wdsel), int'(wd_m));
            for (int q = 0; q < 4; q++) begin
                int a;
                bit p;
                a = q * 64 + 9 + b * 3;
                p = prot_m(bp_m, a);
                wbuf[0] = 8'(b * 16 + q + 1);
                write_txn(9'(a), 1, acks);
                check($sformatf("R6 acked bp=%0d a=%02h", b, a), int'(acks[2:0]), 7);
                poll(t);
                check($sformatf("R6 R3 cycle bp=%0d a=%02h", b, a), int'(t == 1), int'(p));
                if (!p) mem_m[a] = wbuf[0];
                read_seq(9'(a), 1);
                check($sformatf("R5 content bp=%0d a=%02h", b, a), rbuf[0], mem_m[a]);
            end
        end

        // R7 control read ends by itself
        bus_start;
        send_byte(dev(1'b1, 1'b0), k);
        send_byte(8'hFF, k);
        bus_start;
        send_byte(dev(1'b0, 1'b1), k);
        recv_byte(d, 1'b1);
        check("R7 control byte", d, creg_m(1'b0));
        recv_byte(d, 1'b0);
        check("R7 released after one byte", d, 8'hFF);
        bus_stop;
        check("R1 line released at end", int'(sda_pull), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule